// File: doc/BRIEF.md
# Multi-Mode UART With Address Filtering

This block is an asynchronous serial transceiver controlled through a small register port. A two-bit mode field selects one of three frame formats: an 8-bit frame paced by an external tick, a 9-bit frame paced by an internal fixed divider of the clock, or a 9-bit frame paced by the external tick. The remaining mode code belongs to a synchronous shift function that this block does not implement, and in that code the serial engines stay idle. Both directions run on a 16x oversample tick. The receiver votes each bit from samples 7, 8 and 9. In the 9-bit modes an address filter can hold back the receive flag so that only address frames aimed at this node get through. In the 8-bit mode the same filter also requires a valid stop bit. Any bad stop bit sets a sticky framing-error flag, which is read through bit 7 of the control register in place of the high mode bit.

Both engines are state machines with the states IDLE, START, DATA, NINTH and STOP. The transmitter moves from IDLE to START when the data register is written. Each later move happens at the end of a 16-tick bit. START goes to DATA. DATA goes to NINTH after the eighth bit in a 9-bit mode, or to STOP in the 8-bit mode. NINTH goes to STOP, and STOP goes back to IDLE. The receiver moves from IDLE to START on a falling edge of the synchronised line while reception is enabled. START goes back to IDLE if the vote gives a 1, which is a false start. Otherwise START goes to DATA at the end of the bit. DATA and NINTH advance the same way as in the transmitter. STOP returns to IDLE at the vote point in the middle of the stop bit, and the frame is delivered there. Clearing the receive-enable bit forces the receiver to IDLE from any state.

Register map (byte addresses): 0 control, 1 data (a write sends, a read returns the receive buffer), 2 node address, 3 address mask, 4 auxiliary (bit 0 selects whether bit 7 of the control register shows the error flag, bit 1 selects double speed). Control bits: 7 high mode bit or error flag, 6 low mode bit, 5 address-filter enable, 4 receive enable, 3 transmit ninth bit, 2 received ninth bit, 1 transmit flag, 0 receive flag.

Top module: `sport_top`

## Requirements
- R1: With mode bits 00 a data write starts no frame (`txd_o` stays 1), no flag is raised, and a frame on `rxd_i` is ignored.
- R2: After reset all flags are 0 and `txd_o` is 1. A frame is a 0 start bit, the data bits LSB first, an optional ninth bit and a 1 stop bit, each 16 ticks long. In mode 01 the tick is `baud_tick_i`.
- R3: In modes 10 and 11 the transmitter sends control bit 3 as the ninth bit. Mode 01 sends no ninth bit.
- R4: In mode 10 a bit lasts 16 clocks when auxiliary bit 1 is 1 and 32 clocks when it is 0.
- R5: The transmit flag (control bit 1, `tx_flag_o`) rises when the stop bit starts. It is still 0 during the last data bit, and it stays set until software writes 0 to it.
- R6: With the filter off, a frame received in a 9-bit mode sets the receive flag (control bit 0, `rx_flag_o`) in the middle of the stop bit. It loads the data byte into the buffer and the ninth bit into control bit 2, and the flag stays set until written 0.
- R7: In mode 01 with the filter off, control bit 2 takes the received stop bit.
- R8: In mode 01 with the filter on, a frame is accepted only if its stop bit is 1 and the byte matches. A rejected frame leaves the flag at 0 and the buffer unchanged.
- R9: In modes 10 and 11 with the filter on, a frame is accepted only if its ninth bit is 1 and the byte matches. A byte matches when it equals the node address on every bit where the mask is 1, or when it equals the node address OR mask.
- R10: A stop bit of 0 sets the framing-error flag whatever auxiliary bit 0 holds. A later good frame leaves the flag set, and only a control write with auxiliary bit 0 set clears it.
- R11: Control bit 7 reads and writes the error flag when auxiliary bit 0 is 1, and the high mode bit when auxiliary bit 0 is 0.
- R12: While control bit 4 is 0, no frame is received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data, combinational |
| baud_tick_i | input | 1 | External 16x tick for modes 01 and 11 |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| tx_flag_o | output | 1 | Transmit flag |
| rx_flag_o | output | 1 | Receive flag |

## Verification
The transmit flag appears on the same clock edge at which `txd_o` rises for the stop bit. The monitor therefore reads the flag at the centre of the last data bit, where it must be 0, and again at the centre of the stop bit, where it must be 1. Every line bit is sampled at its centre, half a bit after the detected start edge and then one bit period apart, so tick phase and the divider choice cannot shift a sample across a bit boundary. On the receive side the line passes two synchronising flops, the vote falls on sample 9 of the stop bit, and the flag, buffer and error flag are registered one clock later. The bench reads these results only after the stop bit has ended plus half a bit. It reads registers half a clock after writing them.

// File: rtl/sport_pkg.sv
package sport_pkg;
    // Mode field as {high bit, low bit} of the control register
    typedef enum logic [1:0] {
        MD_SHIFT = 2'b00,
        MD_U8    = 2'b01,
        MD_U9F   = 2'b10,
        MD_U9V   = 2'b11
    } mode_t;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_START,
        FS_DATA,
        FS_NINTH,
        FS_STOP
    } fstate_t;

    localparam logic [2:0] A_CTL = 3'd0;
    localparam logic [2:0] A_DAT = 3'd1;
    localparam logic [2:0] A_ADR = 3'd2;
    localparam logic [2:0] A_MSK = 3'd3;
    localparam logic [2:0] A_AUX = 3'd4;
endpackage

// File: rtl/sport_tick.sv
module sport_tick
    import sport_pkg::*;
#(
    parameter int SLOW_DIV = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  dbl,
    input  logic  tick_var,
    output logic  tick
);
    localparam int CW = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;

    logic [CW-1:0] dcnt;
    logic          slow_tick;

    assign slow_tick = (dcnt == CW'(SLOW_DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         dcnt <= '0;
        else if (slow_tick) dcnt <= '0;
        else                dcnt <= dcnt + 1'b1;
    end

    always_comb begin
        unique case (mode)
            MD_U9F:         tick = dbl ? 1'b1 : slow_tick;
            MD_U8, MD_U9V:  tick = tick_var;
            default:        tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/sport_tx.sv
module sport_tx
    import sport_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          start,
    input  logic [DW-1:0] data,
    input  logic          nine_en,
    input  logic          nine_bit,
    output logic          txd,
    output logic          busy,
    output logic          stop_enter
);
    localparam int CW = $clog2(OSR);
    localparam int BW = $clog2(DW);

    fstate_t       st, st_n;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic [DW-1:0] sh;
    logic          n9, nen;
    logic          bit_end, last;

    assign bit_end = tick && (cnt == CW'(OSR - 1));
    assign last    = (bidx == BW'(DW - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        unique case (st)
            FS_IDLE:  if (start)           st_n = FS_START;
            FS_START: if (bit_end)         st_n = FS_DATA;
            FS_DATA:  if (bit_end && last) st_n = nen ? FS_NINTH : FS_STOP;
            FS_NINTH: if (bit_end)         st_n = FS_STOP;
            FS_STOP:  if (bit_end)         st_n = FS_IDLE;
            default:                       st_n = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
            n9   <= 1'b0;
            nen  <= 1'b0;
        end else if (st == FS_IDLE) begin
            cnt  <= '0;
            bidx <= '0;
            if (start) begin
                sh  <= data;
                n9  <= nine_bit;
                nen <= nine_en;
            end
        end else if (tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
            if (bit_end && st == FS_DATA) bidx <= bidx + 1'b1;
        end
    end

    always_comb begin
        unique case (st)
            FS_START: txd = 1'b0;
            FS_DATA:  txd = sh[bidx];
            FS_NINTH: txd = n9;
            default:  txd = 1'b1;
        endcase
    end

    assign busy       = (st != FS_IDLE);
    assign stop_enter = bit_end && ((st == FS_DATA && last && !nen) || st == FS_NINTH);
endmodule

// File: rtl/sport_rx.sv
module sport_rx
    import sport_pkg::*;
#(
    parameter int DW  = 8,
    parameter int OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          en,
    input  logic          rxd,
    input  logic          nine_en,
    output logic          done,
    output logic [DW-1:0] data,
    output logic          bit9,
    output logic          stop_ok
);
    localparam int CW  = $clog2(OSR);
    localparam int BW  = $clog2(DW);
    localparam int MID = OSR / 2;

    fstate_t       st, st_n;
    logic          s1, s2, prv;
    logic [1:0]    v;
    logic [CW-1:0] cnt;
    logic [BW-1:0] bidx;
    logic          bit_end, last, vote_pt, voted, fall;

    assign bit_end = tick && (cnt == CW'(OSR - 1));
    assign vote_pt = tick && (cnt == CW'(MID + 1));
    assign last    = (bidx == BW'(DW - 1));
    assign fall    = prv && !s2;
    assign voted   = (v[1] & v[0]) | (v[1] & s2) | (v[0] & s2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_IDLE;
        else        st <= st_n;
    end

    always_comb begin
        st_n = st;
        if (!en) st_n = FS_IDLE;
        else begin
            unique case (st)
                FS_IDLE:  if (fall) st_n = FS_START;
                FS_START: begin
                    if (vote_pt && voted) st_n = FS_IDLE;
                    else if (bit_end)     st_n = FS_DATA;
                end
                FS_DATA:  if (bit_end && last) st_n = nine_en ? FS_NINTH : FS_STOP;
                FS_NINTH: if (bit_end)         st_n = FS_STOP;
                FS_STOP:  if (vote_pt)         st_n = FS_IDLE;
                default:                       st_n = FS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1 <= 1'b1; s2 <= 1'b1; prv <= 1'b1;
            v <= '0; cnt <= '0; bidx <= '0;
            done <= 1'b0; data <= '0; bit9 <= 1'b0; stop_ok <= 1'b0;
        end else begin
            s1   <= rxd;
            s2   <= s1;
            prv  <= s2;
            done <= 1'b0;
            if (st == FS_IDLE) begin
                cnt  <= '0;
                bidx <= '0;
            end else if (tick) begin
                cnt <= bit_end ? '0 : cnt + 1'b1;
                if (bit_end && st == FS_DATA) bidx <= bidx + 1'b1;
                if (cnt == CW'(MID - 1) || cnt == CW'(MID)) v <= {v[0], s2};
                if (vote_pt) begin
                    if (st == FS_DATA)  data <= {voted, data[DW-1:1]};
                    if (st == FS_NINTH) bit9 <= voted;
                    if (st == FS_STOP) begin
                        done    <= en;
                        stop_ok <= voted;
                        if (!nine_en) bit9 <= voted;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/sport_top.sv
module sport_top
    import sport_pkg::*;
#(
    parameter int DW       = 8,
    parameter int OSR      = 16,
    parameter int SLOW_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [2:0]    rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          baud_tick_i,
    input  logic          rxd_i,
    output logic          txd_o,
    output logic          tx_flag_o,
    output logic          rx_flag_o
);
    logic          sm0_q, sm1_q, aen_q, ren_q, tx9_q, rx9_q, tif_q, rif_q;
    logic          fe_q, fe_sel, dbl_q;
    logic [DW-1:0] rbuf_q, adr_q, msk_q;
    mode_t         mode;
    logic          tick, ctl_wr, tx_go, tx_busy, tx_stop, rx_on;
    logic          rx_done, rx_bit9, rx_stop_ok, hit, accept;
    logic [DW-1:0] rx_data;

    assign mode   = mode_t'({sm0_q, sm1_q});
    assign ctl_wr = wr_en && (wr_addr == A_CTL);
    assign tx_go  = wr_en && (wr_addr == A_DAT) && !tx_busy && (mode != MD_SHIFT);
    assign rx_on  = ren_q && (mode != MD_SHIFT);

    sport_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .mode(mode), .dbl(dbl_q),
        .tick_var(baud_tick_i), .tick(tick)
    );

    sport_tx #(.DW(DW), .OSR(OSR)) u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .start(tx_go), .data(wr_data),
        .nine_en(mode[1]), .nine_bit(tx9_q), .txd(txd_o), .busy(tx_busy),
        .stop_enter(tx_stop)
    );

    sport_rx #(.DW(DW), .OSR(OSR)) u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(rx_on), .rxd(rxd_i),
        .nine_en(mode[1]), .done(rx_done), .data(rx_data), .bit9(rx_bit9),
        .stop_ok(rx_stop_ok)
    );

    // Node match: masked compare, or the all-nodes pattern address|mask
    assign hit = (((rx_data ^ adr_q) & msk_q) == '0) || (rx_data == (adr_q | msk_q));

    always_comb begin
        unique case (mode)
            MD_U8:          accept = !aen_q || (rx_stop_ok && hit);
            MD_U9F, MD_U9V: accept = !aen_q || (rx_bit9 && hit);
            default:        accept = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {sm0_q, sm1_q, aen_q, ren_q, tx9_q, rx9_q, tif_q, rif_q} <= '0;
            fe_q <= 1'b0; fe_sel <= 1'b0; dbl_q <= 1'b0;
            rbuf_q <= '0; adr_q <= '0; msk_q <= '0;
        end else begin
            if (wr_en) begin
                unique case (wr_addr)
                    A_CTL: begin
                        if (fe_sel) fe_q  <= wr_data[7];
                        else        sm0_q <= wr_data[7];
                        {sm1_q, aen_q, ren_q, tx9_q, rx9_q, tif_q, rif_q} <= wr_data[6:0];
                    end
                    A_ADR:   adr_q <= wr_data;
                    A_MSK:   msk_q <= wr_data;
                    A_AUX:   {dbl_q, fe_sel} <= wr_data[1:0];
                    default: ;
                endcase
            end
            // Hardware events win over a same-cycle software write
            if (tx_stop) tif_q <= 1'b1;
            if (rx_done) begin
                if (!rx_stop_ok) fe_q <= 1'b1;
                if (accept) begin
                    rif_q  <= 1'b1;
                    rbuf_q <= rx_data;
                    rx9_q  <= rx_bit9;
                end
            end
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTL:   rd_data = DW'({fe_sel ? fe_q : sm0_q, sm1_q, aen_q, ren_q,
                                    tx9_q, rx9_q, tif_q, rif_q});
            A_DAT:   rd_data = rbuf_q;
            A_ADR:   rd_data = adr_q;
            A_MSK:   rd_data = msk_q;
            A_AUX:   rd_data = DW'({dbl_q, fe_sel});
            default: rd_data = '0;
        endcase
    end

    assign tx_flag_o = tif_q;
    assign rx_flag_o = rif_q;
endmodule

// File: rtl/sport_chk.sv
module sport_chk (
    input logic clk,
    input logic rst_n,
    input logic ctl_wr,
    input logic fe_sel,
    input logic fe,
    input logic rx_flag,
    input logic tx_flag,
    input logic txd,
    input logic tx_busy,
    input logic frame_done,
    input logic rx_en,
    input logic aen,
    input logic nine_mode,
    input logic fbit9
);
    a_r2_idle_line_high: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_busy |-> txd);

    a_r5_tx_flag_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_flag) && !$past(ctl_wr) |-> txd);

    a_r6_rx_flag_from_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_flag) |-> $past(frame_done) || $past(ctl_wr));

    a_r9_ninth_zero_filtered: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done && aen && nine_mode && !fbit9 && !ctl_wr |=> rx_flag == $past(rx_flag));

    a_r10_fe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fe && !(ctl_wr && fe_sel) |=> fe);

    a_r12_rx_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(rx_en));
endmodule

bind sport_top sport_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .fe_sel(fe_sel), .fe(fe_q),
    .rx_flag(rif_q), .tx_flag(tif_q), .txd(txd_o), .tx_busy(tx_busy),
    .frame_done(rx_done), .rx_en(rx_on), .aen(aen_q), .nine_mode(mode[1]),
    .fbit9(rx_bit9)
);

// File: tb/sport_top_test.sv
module sport_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       baud_tick_i = 1'b0;
    logic       rxd_i = 1'b1;
    logic       txd_o, tx_flag_o, rx_flag_o;

    always #4 clk = ~clk;

    sport_top uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .baud_tick_i(baud_tick_i), .rxd_i(rxd_i),
        .txd_o(txd_o), .tx_flag_o(tx_flag_o), .rx_flag_o(rx_flag_o)
    );

    int total = 0;
    int bad = 0;

    // Shadow of the software-visible settings
    logic [1:0] m_mode = 2'b00;
    bit   m_aen = 0, m_ren = 0, m_tx9 = 0, m_sel = 0, m_dbl = 0;
    logic [7:0] m_adr = 8'h00, m_msk = 8'h00, m_rbuf = 8'h00;
    int   bit_clk = 16;

    typedef struct { logic [7:0] d; bit has9; bit b9; } txe_t;
    txe_t tx_q[$];

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // External 16x tick: one pulse every 4 clocks
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            baud_tick_i = 1'b1;
            @(negedge clk);
            baud_tick_i = 1'b0;
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    function automatic logic [7:0] ctl_val();
        return {m_mode, m_aen, m_ren, m_tx9, 3'b000};
    endfunction

    task automatic upd_bitclk();
        if (m_mode == 2'b10) bit_clk = m_dbl ? 16 : 32;
        else if (m_mode == 2'b00) bit_clk = 16;
        else bit_clk = 64;
    endtask

    task automatic put_ctl();
        reg_wr(3'd0, ctl_val());
        upd_bitclk();
    endtask

    task automatic put_aux();
        reg_wr(3'd4, {6'b0, m_dbl, m_sel});
        upd_bitclk();
    endtask

    task automatic cfg(input logic [1:0] md, input bit aen, input bit ren, input bit t9);
        m_mode = md; m_aen = aen; m_ren = ren; m_tx9 = t9;
        put_ctl();
    endtask

    // Driver: queue the expected frame, then write the data register
    task automatic send_tx(input logic [7:0] d);
        put_ctl();
        tx_q.push_back('{d: d, has9: m_mode[1], b9: m_tx9});
        reg_wr(3'd1, d);
        repeat (bit_clk * 12) @(negedge clk);
    endtask

    // Monitor: decode txd_o at bit centres and compare against the queue
    initial begin
        bit prev;
        prev = 1'b1;
        forever begin
            @(negedge clk);
            if (prev && !txd_o) begin
                int bc;
                logic [7:0] got;
                txe_t e;
                bc = bit_clk;
                if (tx_q.size() == 0) begin
                    chk_eq("R1 unexpected frame on txd", 1, 0);
                    e = '{d: 8'h00, has9: 1'b0, b9: 1'b0};
                end else e = tx_q.pop_front();
                repeat (bc / 2) @(negedge clk);
                chk_eq("R2 start bit", txd_o, 0);
                for (int i = 0; i < 8; i++) begin
                    repeat (bc) @(negedge clk);
                    got[i] = txd_o;
                    if (i == 7) chk_eq("R5 tx flag low in last data bit", tx_flag_o, 0);
                end
                if (e.has9) begin
                    repeat (bc) @(negedge clk);
                    chk_eq("R3 ninth bit", txd_o, e.b9);
                end
                repeat (bc) @(negedge clk);
                chk_eq("R2 stop bit", txd_o, 1);
                chk_eq("R5 tx flag at stop", tx_flag_o, 1);
                if (bc == 32) chk_eq("R4 data at slow fixed rate", got, e.d);
                else          chk_eq("R2 data byte", got, e.d);
                prev = 1'b1;
            end else prev = txd_o;
        end
    end

    task automatic send_rx(input logic [7:0] d, input bit b9, input bit stp);
        int bc;
        bc = bit_clk;
        @(negedge clk);
        rxd_i = 1'b0;
        repeat (bc) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd_i = d[i];
            repeat (bc) @(negedge clk);
        end
        if (m_mode[1]) begin
            rxd_i = b9;
            repeat (bc) @(negedge clk);
        end
        rxd_i = stp;
        repeat (bc) @(negedge clk);
        rxd_i = 1'b1;
        repeat (bc / 2) @(negedge clk);
    endtask

    // Sends one frame, checks flag, buffer and ninth bit, then clears flags (sel must be 0)
    task automatic rx_frame(input logic [7:0] d, input bit b9, input bit stp, input string req);
        bit hit, acc;
        logic [7:0] v;
        hit = (((d ^ m_adr) & m_msk) == 8'h00) || (d == (m_adr | m_msk));
        if (!m_ren || m_mode == 2'b00) acc = 0;
        else if (m_mode == 2'b01)      acc = !m_aen || (stp && hit);
        else                           acc = !m_aen || (b9 && hit);
        send_rx(d, b9, stp);
        chk_eq({req, " rx flag"}, rx_flag_o, acc);
        reg_rd(3'd1, v);
        chk_eq({req, " buffer"}, v, acc ? d : m_rbuf);
        if (acc) begin
            m_rbuf = d;
            reg_rd(3'd0, v);
            chk_eq({req, " received ninth"}, v[2], (m_mode == 2'b01) ? stp : b9);
        end
        put_ctl();
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int lows;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state (R2)
        chk_eq("R2 reset txd", txd_o, 1);
        chk_eq("R2 reset tx flag", tx_flag_o, 0);
        chk_eq("R2 reset rx flag", rx_flag_o, 0);
        reg_rd(3'd0, v);
        chk_eq("R2 reset control", v, 8'h00);

        // Fixed-rate 9-bit mode, double speed
        m_dbl = 1; m_sel = 0; put_aux();
        cfg(2'b10, 0, 1, 1);
        reg_rd(3'd0, v);
        chk_eq("R11 control readback with select 0", v, ctl_val());
        send_tx(8'hA5);
        chk_eq("R5 tx flag sticky", tx_flag_o, 1);
        put_ctl();
        chk_eq("R5 tx flag cleared by write", tx_flag_o, 0);
        m_tx9 = 0;
        send_tx(8'h3C);

        // Slow fixed rate
        m_dbl = 0; put_aux();
        send_tx(8'h5A);
        m_dbl = 1; put_aux();

        // Reception, filter off (R6)
        send_rx(8'h96, 0, 1);
        repeat (40) @(negedge clk);
        chk_eq("R6 rx flag sticky", rx_flag_o, 1);
        reg_rd(3'd1, v);
        chk_eq("R6 buffer", v, 8'h96);
        m_rbuf = 8'h96;
        reg_rd(3'd0, v);
        chk_eq("R6 received ninth", v[2], 0);
        put_ctl();
        chk_eq("R6 rx flag cleared", rx_flag_o, 0);
        rx_frame(8'h4B, 1, 1, "R6");

        // Address filter in a 9-bit mode (R9)
        m_adr = 8'h12; m_msk = 8'h0F;
        reg_wr(3'd2, m_adr);
        reg_wr(3'd3, m_msk);
        cfg(2'b10, 1, 1, 0);
        rx_frame(8'h42, 1, 1, "R9 given match");
        rx_frame(8'h62, 0, 1, "R9 ninth zero");
        rx_frame(8'h35, 1, 1, "R9 no match");
        rx_frame(8'h1F, 1, 1, "R9 broadcast");
        cfg(2'b11, 1, 1, 0);
        rx_frame(8'h52, 1, 1, "R9 variable mode");

        // Bit 7 aliasing: with select 1 a write must not touch the mode (R11)
        cfg(2'b10, 0, 1, 0);
        m_sel = 1; put_aux();
        reg_wr(3'd0, {1'b0, ctl_val()[6:0]});
        m_sel = 0; put_aux();
        reg_rd(3'd0, v);
        chk_eq("R11 mode kept under select 1", v[7:6], 2'b10);

        // Receive disabled (R12)
        cfg(2'b10, 0, 0, 0);
        rx_frame(8'hE7, 1, 1, "R12");

        // 8-bit mode on external tick
        cfg(2'b01, 0, 1, 0);
        send_tx(8'hC3);
        rx_frame(8'h3C, 0, 0, "R7 bad stop");
        rx_frame(8'h81, 0, 1, "R7 good stop");
        m_sel = 1; put_aux();
        reg_rd(3'd0, v);
        chk_eq("R10 error sticky after good frame", v[7], 1);
        reg_wr(3'd0, {1'b0, ctl_val()[6:0]});
        reg_rd(3'd0, v);
        chk_eq("R10 error cleared by write", v[7], 0);
        m_sel = 0; put_aux();
        reg_rd(3'd0, v);
        chk_eq("R11 select 0 shows mode", v[7:6], 2'b01);

        // Filter in 8-bit mode (R8)
        cfg(2'b01, 1, 1, 0);
        rx_frame(8'h72, 0, 1, "R8 match good stop");
        rx_frame(8'h72, 0, 0, "R8 match bad stop");
        rx_frame(8'h55, 0, 1, "R8 no match");
        rx_frame(8'h1F, 0, 1, "R8 broadcast");
        m_sel = 1; put_aux();
        reg_rd(3'd0, v);
        chk_eq("R10 error set by filtered frame", v[7], 1);
        reg_wr(3'd0, {1'b0, ctl_val()[6:0]});
        m_sel = 0; put_aux();

        // Shift mode code: engines idle (R1)
        cfg(2'b00, 0, 1, 0);
        reg_wr(3'd1, 8'h0F);
        lows = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!txd_o) lows++;
        end
        chk_eq("R1 txd stays high", lows, 0);
        chk_eq("R1 no tx flag", tx_flag_o, 0);
        rx_frame(8'hAA, 0, 1, "R1");

        chk_eq("R2 all queued frames seen", tx_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule